// File: doc/BRIEF.md
# Credit-Gated Packet Transmit Admission

This block decides, cycle by cycle, whether a transmitter may launch its next packet without overrunning the receive buffers at the far end of a link. Every traffic class (posted, non-posted, completion) has two credit types: header credits and data credits. When the link comes up, the far end announces how many credits of each type it has for each class. The gate keeps a running tally of the credits that granted packets have used. It compares that tally with the announced limit before it grants any request. Later credit-return messages from the far end move the limit forward.

Both the consumed tally and the limit are free-running modular counters: 8 bits for header credits and 12 bits for data credits. A request fits when `(limit - (consumed + request)) mod 2^n` is no greater than `2^(n-1)`. An announced value of zero for a credit type means that type is unlimited for its class. The requester offers a packet with `req_valid` and its class and credit cost. The gate answers with `req_ready`, which is computed combinationally from the request and the registered credit state. A packet is taken on a cycle where both signals are high. While waiting, the requester holds the class and cost stable. It may withdraw `req_valid` at any time, because a refused request leaves no state behind. Announced values must not exceed `2^(n-1)`.

Top module: `fc_tx_gate`

## Requirements
- R1: After reset, `req_ready` stays low for every class until an initial announcement (`upd_valid` and `upd_init` both high) has been received for that class.
- R2: After an initial announcement of H header and D data credits (both nonzero), a request costing at most H header and at most D data credits is granted. A request exceeding either amount is refused.
- R3: Each taken packet adds its header and data cost to the class tallies on the clock edge where it is taken. Once the tally reaches the limit, any request with a nonzero cost of that type is refused. A zero-cost request is still granted.
- R4: A credit update (`upd_valid` high, `upd_init` low) replaces the class limits with the supplied absolute counter values. The new limits take effect from the next cycle.
- R5: An initial announcement of zero for one credit type makes that type unlimited for the class, so the type never blocks a grant. The other type is still checked.
- R6: The tallies and limits of each class are independent. Traffic on one class does not change any grant decision on another class.
- R7: When an update and a taken packet fall on the same cycle, the grant in that cycle uses the old limit. The next cycle checks against the new limit and against a tally that includes the packet.
- R8: Limits and tallies wrap modulo 2^8 (header) and 2^12 (data), and admission stays correct across the wrap.
- R9: A request whose class index is not below the number of classes (index 3 with the default three classes) is never granted.
- R10: A credit update for a type that was announced as unlimited is ignored, and that type stays unlimited.
- R11: A new initial announcement for a class clears that class's tallies to zero and loads the new limits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| upd_valid | input | 1 | Credit announcement or update present this cycle |
| upd_init | input | 1 | 1: initial announcement (clears tallies); 0: limit update |
| upd_class | input | 2 | Class index: 0 posted, 1 non-posted, 2 completion |
| upd_hdr | input | 8 | Header credit value (initial amount or absolute limit) |
| upd_dat | input | 12 | Data credit value (initial amount or absolute limit) |
| req_valid | input | 1 | Packet offered |
| req_class | input | 2 | Class index of the offered packet |
| req_hdr | input | 8 | Header credits the packet needs |
| req_dat | input | 12 | Data credits the packet needs |
| req_ready | output | 1 | Packet fits; it is taken when `req_valid` is also high |

## Verification
On every cycle, the assertions check the following. No class is granted before its initial announcement. Out-of-range classes are never granted. `req_ready` holds steady when neither the request nor the credit state has had a reason to change. A zero-cost request, or any request to a class announced as fully unlimited, is granted right after an announcement. The arithmetic of admission can only be shown by the bench's directed scenarios. These cover exact-fit and one-over boundaries, accumulation, limit updates that coincide with a grant, wrap-around of both counter widths, ignored updates on unlimited types, and isolation between classes.

// File: rtl/fc_pkg.sv
package fc_pkg;
  typedef enum logic [1:0] {
    CLS_POSTED    = 2'd0,
    CLS_NONPOSTED = 2'd1,
    CLS_COMPL     = 2'd2
  } fc_class_e;

  localparam int HDR_BITS_DEF = 8;
  localparam int DAT_BITS_DEF = 12;
  localparam int CLASSES_DEF  = 3;
endpackage

// File: rtl/fc_credit_lane.sv
// One credit type of one class: limit, consumed tally, unlimited flag.
module fc_credit_lane #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         arm,
  input  logic         load,
  input  logic [W-1:0] value,
  input  logic         take,
  input  logic [W-1:0] amt,
  output logic         fits
);
  localparam logic [W-1:0] HALF = W'(1) << (W - 1);

  logic [W-1:0] limit_q;
  logic [W-1:0] used_q;
  logic         unl_q;
  logic [W-1:0] gap;

  always_comb begin
    gap  = limit_q - used_q - amt;
    fits = unl_q || (gap <= HALF);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      limit_q <= '0;
      used_q  <= '0;
      unl_q   <= 1'b0;
    end else if (arm) begin
      limit_q <= value;
      used_q  <= '0;
      unl_q   <= (value == '0);
    end else begin
      if (load && !unl_q) limit_q <= value;
      if (take)           used_q  <= used_q + amt;
    end
  end
endmodule

// File: rtl/fc_class_slot.sv
// Header and data lanes of one class plus its armed flag.
module fc_class_slot #(
  parameter int HDR_W = 8,
  parameter int DAT_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             arm,
  input  logic             load,
  input  logic [HDR_W-1:0] hdr_val,
  input  logic [DAT_W-1:0] dat_val,
  input  logic             take,
  input  logic [HDR_W-1:0] hdr_amt,
  input  logic [DAT_W-1:0] dat_amt,
  output logic             ok
);
  logic armed_q;
  logic hdr_fits;
  logic dat_fits;

  always_ff @(posedge clk) begin
    if (!rst_n)   armed_q <= 1'b0;
    else if (arm) armed_q <= 1'b1;
  end

  fc_credit_lane #(.W(HDR_W)) u_hdr (
    .clk(clk), .rst_n(rst_n), .arm(arm), .load(load), .value(hdr_val),
    .take(take), .amt(hdr_amt), .fits(hdr_fits)
  );

  fc_credit_lane #(.W(DAT_W)) u_dat (
    .clk(clk), .rst_n(rst_n), .arm(arm), .load(load), .value(dat_val),
    .take(take), .amt(dat_amt), .fits(dat_fits)
  );

  assign ok = armed_q && hdr_fits && dat_fits;
endmodule

// File: rtl/fc_tx_gate.sv
module fc_tx_gate #(
  parameter int NUM_CLASS = fc_pkg::CLASSES_DEF,
  parameter int HDR_W     = fc_pkg::HDR_BITS_DEF,
  parameter int DAT_W     = fc_pkg::DAT_BITS_DEF,
  parameter int CLS_W     = (NUM_CLASS > 1) ? $clog2(NUM_CLASS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             upd_valid,
  input  logic             upd_init,
  input  logic [CLS_W-1:0] upd_class,
  input  logic [HDR_W-1:0] upd_hdr,
  input  logic [DAT_W-1:0] upd_dat,
  input  logic             req_valid,
  input  logic [CLS_W-1:0] req_class,
  input  logic [HDR_W-1:0] req_hdr,
  input  logic [DAT_W-1:0] req_dat,
  output logic             req_ready
);
  logic [NUM_CLASS-1:0] ok_vec;

  for (genvar c = 0; c < NUM_CLASS; c++) begin : g_cls
    logic hit_upd;
    logic hit_req;
    assign hit_upd = upd_valid && (upd_class == CLS_W'(c));
    assign hit_req = (req_class == CLS_W'(c));

    fc_class_slot #(.HDR_W(HDR_W), .DAT_W(DAT_W)) u_slot (
      .clk    (clk),
      .rst_n  (rst_n),
      .arm    (hit_upd && upd_init),
      .load   (hit_upd && !upd_init),
      .hdr_val(upd_hdr),
      .dat_val(upd_dat),
      .take   (req_valid && req_ready && hit_req),
      .hdr_amt(req_hdr),
      .dat_amt(req_dat),
      .ok     (ok_vec[c])
    );
  end

  always_comb begin
    req_ready = 1'b0;
    for (int c = 0; c < NUM_CLASS; c++) begin
      if (req_class == CLS_W'(c)) req_ready = ok_vec[c];
    end
  end
endmodule

// File: rtl/fc_tx_gate_chk.sv
module fc_tx_gate_chk #(
  parameter int NUM_CLASS = 3,
  parameter int HDR_W     = 8,
  parameter int DAT_W     = 12,
  parameter int CLS_W     = 2
) (
  input logic             clk,
  input logic             rst_n,
  input logic             upd_valid,
  input logic             upd_init,
  input logic [CLS_W-1:0] upd_class,
  input logic [HDR_W-1:0] upd_hdr,
  input logic [DAT_W-1:0] upd_dat,
  input logic             req_valid,
  input logic [CLS_W-1:0] req_class,
  input logic [HDR_W-1:0] req_hdr,
  input logic [DAT_W-1:0] req_dat,
  input logic             req_ready
);
  logic [NUM_CLASS-1:0] seen_init;

  always_ff @(posedge clk) begin
    if (!rst_n) seen_init <= '0;
    else if (upd_valid && upd_init && (int'(upd_class) < NUM_CLASS))
      seen_init[upd_class] <= 1'b1;
  end

  // R1
  a_r1_armed_first: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_ready && (int'(req_class) < NUM_CLASS)) |-> seen_init[req_class]);

  // R9
  a_r9_bad_class: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(req_class) >= NUM_CLASS) |-> !req_ready);

  // R4 / R7: decision only moves after a grant, an update or a new request
  a_r4_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(upd_valid) && !$past(req_valid && req_ready) && $stable(req_class)
     && $stable(req_hdr) && $stable(req_dat)) |-> $stable(req_ready));

  // R11
  a_r11_fresh_zero: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_valid && upd_init) && (req_class == $past(upd_class))
     && (req_hdr == '0) && (req_dat == '0)) |-> req_ready);

  // R5
  a_r5_unlimited: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(upd_valid && upd_init && (upd_hdr == '0) && (upd_dat == '0))
     && (req_class == $past(upd_class))) |-> req_ready);
endmodule

bind fc_tx_gate fc_tx_gate_chk #(
  .NUM_CLASS(NUM_CLASS), .HDR_W(HDR_W), .DAT_W(DAT_W), .CLS_W(CLS_W)
) u_chk (
  .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_init(upd_init),
  .upd_class(upd_class), .upd_hdr(upd_hdr), .upd_dat(upd_dat),
  .req_valid(req_valid), .req_class(req_class), .req_hdr(req_hdr),
  .req_dat(req_dat), .req_ready(req_ready)
);

// File: tb/sim_fc_tx_gate.sv
`timescale 1ns/1ps
module sim_fc_tx_gate;
  import fc_pkg::*;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        upd_valid = 1'b0;
  logic        upd_init = 1'b0;
  logic [1:0]  upd_class = '0;
  logic [7:0]  upd_hdr = '0;
  logic [11:0] upd_dat = '0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_class = '0;
  logic [7:0]  req_hdr = '0;
  logic [11:0] req_dat = '0;
  logic        req_ready;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  fc_tx_gate u0 (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_init(upd_init),
    .upd_class(upd_class), .upd_hdr(upd_hdr), .upd_dat(upd_dat),
    .req_valid(req_valid), .req_class(req_class), .req_hdr(req_hdr),
    .req_dat(req_dat), .req_ready(req_ready)
  );

  task automatic chk(string tag, logic act, logic exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: req_ready=%0b expected %0b", tag, act, exp);
    end
  endtask

  task automatic announce(int c, int h, int d, bit init);
    upd_valid = 1'b1; upd_init = init;
    upd_class = 2'(c); upd_hdr = 8'(h); upd_dat = 12'(d);
    @(negedge clk);
    upd_valid = 1'b0; upd_init = 1'b0;
  endtask

  task automatic probe(int c, int h, int d, logic exp, string tag);
    req_valid = 1'b0;
    req_class = 2'(c); req_hdr = 8'(h); req_dat = 12'(d);
    #1 chk(tag, req_ready, exp);
    @(negedge clk);
  endtask

  task automatic send(int c, int h, int d, logic exp, string tag);
    req_valid = 1'b1;
    req_class = 2'(c); req_hdr = 8'(h); req_dat = 12'(d);
    #1 chk(tag, req_ready, exp);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic t_reset();
    probe(CLS_POSTED, 0, 0, 1'b0, "R1 posted before init");
    probe(CLS_NONPOSTED, 0, 0, 1'b0, "R1 nonposted before init");
    probe(CLS_COMPL, 0, 0, 1'b0, "R1 completion before init");
  endtask

  task automatic t_basic();
    announce(CLS_POSTED, 4, 16, 1'b1);
    probe(CLS_POSTED, 4, 16, 1'b1, "R2 exact fit");
    probe(CLS_POSTED, 5, 0, 1'b0, "R2 header one over");
    probe(CLS_POSTED, 0, 17, 1'b0, "R2 data one over");
  endtask

  task automatic t_consume();
    send(CLS_POSTED, 2, 8, 1'b1, "R3 first packet");
    send(CLS_POSTED, 2, 8, 1'b1, "R3 second packet");
    probe(CLS_POSTED, 1, 0, 1'b0, "R3 header exhausted");
    probe(CLS_POSTED, 0, 1, 1'b0, "R3 data exhausted");
    probe(CLS_POSTED, 0, 0, 1'b1, "R3 zero cost");
  endtask

  task automatic t_update();
    announce(CLS_POSTED, 6, 20, 1'b0);
    probe(CLS_POSTED, 2, 4, 1'b1, "R4 raised limit fits");
    probe(CLS_POSTED, 3, 0, 1'b0, "R4 beyond raised limit");
  endtask

  task automatic t_same_cycle();
    upd_valid = 1'b1; upd_init = 1'b0;
    upd_class = CLS_POSTED; upd_hdr = 8'd10; upd_dat = 12'd30;
    req_valid = 1'b1; req_class = CLS_POSTED; req_hdr = 8'd2; req_dat = 12'd4;
    #1 chk("R7 grant on old limit", req_ready, 1'b1);
    @(negedge clk);
    upd_valid = 1'b0; req_valid = 1'b0;
    probe(CLS_POSTED, 4, 10, 1'b1, "R7 new limit and tally");
    probe(CLS_POSTED, 5, 0, 1'b0, "R7 header over");
    probe(CLS_POSTED, 0, 11, 1'b0, "R7 data over");
  endtask

  task automatic t_unlimited();
    announce(CLS_NONPOSTED, 0, 0, 1'b1);
    send(CLS_NONPOSTED, 200, 4000, 1'b1, "R5 unlimited big");
    send(CLS_NONPOSTED, 200, 4000, 1'b1, "R5 unlimited again");
    announce(CLS_NONPOSTED, 1, 1, 1'b0);
    probe(CLS_NONPOSTED, 5, 5, 1'b1, "R10 update ignored");
    announce(CLS_COMPL, 2, 0, 1'b1);
    probe(CLS_COMPL, 2, 4000, 1'b1, "R5 data only unlimited");
    probe(CLS_COMPL, 3, 0, 1'b0, "R5 header still checked");
  endtask

  task automatic t_independent();
    send(CLS_COMPL, 2, 100, 1'b1, "R6 completion packet");
    probe(CLS_POSTED, 4, 10, 1'b1, "R6 posted unaffected");
    probe(CLS_COMPL, 1, 0, 1'b0, "R6 completion exhausted");
  endtask

  task automatic t_wrap();
    announce(CLS_POSTED, 100, 2000, 1'b1);
    send(CLS_POSTED, 100, 2000, 1'b1, "R8 lap one");
    announce(CLS_POSTED, 200, 4000, 1'b0);
    send(CLS_POSTED, 100, 2000, 1'b1, "R8 lap two");
    announce(CLS_POSTED, 44, 1904, 1'b0);
    send(CLS_POSTED, 100, 2000, 1'b1, "R8 across wrap");
    probe(CLS_POSTED, 1, 0, 1'b0, "R8 header full after wrap");
    probe(CLS_POSTED, 0, 1, 1'b0, "R8 data full after wrap");
  endtask

  task automatic t_reinit();
    announce(CLS_POSTED, 3, 3, 1'b1);
    probe(CLS_POSTED, 3, 3, 1'b1, "R11 tally cleared");
    probe(CLS_POSTED, 4, 0, 1'b0, "R11 new limit");
  endtask

  task automatic t_bad_class();
    probe(3, 0, 0, 1'b0, "R9 class index 3");
  endtask

  initial begin
    #(5.0 * 200000);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_bad_class();
    t_basic();
    t_consume();
    t_update();
    t_same_cycle();
    t_unlimited();
    t_independent();
    t_wrap();
    t_reinit();
    t_bad_class();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule